// File: doc/BRIEF.md
# Parity-Guarded AES Substitution Stage

This block is one byte lane of an AES round, reduced to its most exposed point. A plaintext byte is combined with a key byte by XOR. The result goes through a combinational AES substitution, and the substituted byte is stored in an output register. A single check bit travels with the byte through the stage. It is predicted from the two operand bytes before the XOR and then verified before the substitution. A second check bit comes out of the substitution table itself and is verified on the result. If either verification fails, the register stores a fixed error pattern in place of the data and raises an error flag.

The output register is loaded only by a write strobe. In every cycle without a write, the data byte is cleared to zero, so each operation starts from the same register state. The error flag keeps its value until the next write. Two mask ports allow faults to be injected for test: one flips bits of the protected word that enters the substitution, and the other flips bits of the protected word that leaves it. Both masks are sampled only during a write.

Top module: `sbg_top`

## Requirements
- R1: While reset (`rst_n` low, sampled on the clock edge) is applied, `res_q` becomes 0x00 and `err_q` becomes 0.
- R2: A write (`wr_en` high at a rising edge) with both fault masks zero loads `res_q` with the AES S-box of `pt_byte XOR key_byte` at that edge, and loads `err_q` with 0.
- R3: At each rising edge where `wr_en` is low, `res_q` becomes 0x00.
- R4: `err_q` keeps its value at every rising edge where `wr_en` is low.
- R5: A write whose `flt_pre` mask has exactly one bit set, with `flt_post` zero, loads `res_q` with 0x01 and `err_q` with 1. This holds for any of the 9 bits. Bits 7:0 of a mask cover the data byte, and bit 8 covers the check bit.
- R6: A write whose `flt_post` mask has exactly one bit set, with `flt_pre` zero, loads `res_q` with 0x01 and `err_q` with 1. This holds for any of the 9 bits.
- R7: The fault masks have no effect on `res_q` or `err_q` at edges where `wr_en` is low.
- R8: Writes on consecutive edges each load their own result. No cleared cycle falls between them, and a fault-free write after a faulty one returns `err_q` to 0.
- R9: The check bit is the XOR of the eight data bits, so the 9-bit protected word always has even parity. A fault that flips two data bits before the substitution is therefore not detected. The register then holds the S-box of the corrupted byte, with `err_q` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe; loads the output register |
| pt_byte | input | 8 | Plaintext byte |
| key_byte | input | 8 | Key byte |
| flt_pre | input | 9 | Test mask XORed onto the protected word entering the S-box (bit 8 = check bit) |
| flt_post | input | 9 | Test mask XORed onto the protected word leaving the S-box (bit 8 = check bit) |
| res_q | output | 8 | Registered result byte, or 0x01 on a detected error |
| err_q | output | 1 | Registered error flag, held until the next write |

## Verification
Two pairs of behaviour can coincide in a single cycle. The first pair is the clear-after-write rule and a new write. The bench issues writes on consecutive edges and expects the second result to appear with no zero between the two results. The second pair is the input check and the output check. Random trials set faults on both masks in the same write, and also set two-bit input faults that get past the input check. Each case is judged against a bench model that derives the expected byte and flag from R2, R5, R6 and R9.

// File: rtl/sbg_pkg.sv
// Package: shared widths, word types and the AES substitution math.
// Assumes the AES field polynomial x^8+x^4+x^3+x+1 and an even-parity check bit.
package sbg_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = BYTE_W + 1;
    localparam int TBL_N  = 1 << BYTE_W;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;

    // GF(2^8) multiply, reduced by the AES polynomial
    function automatic byte_t gf_mul(input byte_t a_in, input byte_t b_in);
        byte_t a;
        byte_t b;
        byte_t p;
        logic  hi;
        a = a_in;
        b = b_in;
        p = '0;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[0]) p = p ^ a;
            hi = a[BYTE_W-1];
            a  = a << 1;
            if (hi) a = a ^ 8'h1b;
            b = b >> 1;
        end
        return p;
    endfunction

    // Multiplicative inverse as x^254 (zero maps to zero)
    function automatic byte_t gf_inv(input byte_t x);
        byte_t r;
        byte_t base;
        byte_t e;
        r    = 8'h01;
        base = x;
        e    = 8'd254;
        for (int i = 0; i < BYTE_W; i++) begin
            if (e[i]) r = gf_mul(r, base);
            base = gf_mul(base, base);
        end
        return r;
    endfunction

    // Rotate a byte left by n
    function automatic byte_t rotl(input byte_t v, input int n);
        return byte_t'((v << n) | (v >> (BYTE_W - n)));
    endfunction

    // Forward AES substitution: inverse followed by the affine map
    function automatic byte_t sbox_fwd(input byte_t x);
        byte_t s;
        s = gf_inv(x);
        return s ^ rotl(s, 1) ^ rotl(s, 2) ^ rotl(s, 3) ^ rotl(s, 4) ^ 8'h63;
    endfunction

    // Protected word: check bit on top of the data byte
    function automatic word_t protect(input byte_t d);
        return {^d, d};
    endfunction

endpackage

// File: rtl/sbg_encode.sv
// Module: sbg_encode
// Builds the protected S-box input word. The check bit is predicted from the
// parities of the two operands, not recomputed from the XOR result, so a fault
// on the XOR path shows up as a parity mismatch.
module sbg_encode
    import sbg_pkg::*;
(
    input  byte_t pt_i,
    input  byte_t key_i,
    output word_t word_o
);

    // Combine operands and predict the check bit
    always_comb begin
        word_o = {(^pt_i) ^ (^key_i), pt_i ^ key_i};
    end

endmodule

// File: rtl/sbg_check.sv
// Module: sbg_check
// Even-parity checker for a protected word of W bits. Flags a word whose
// total parity is odd; assumes exactly one check bit per word.
module sbg_check #(
    parameter int W = 9
) (
    input  logic [W-1:0] word_i,
    output logic         bad_o
);

    // Reduce the whole word; odd parity means an error
    always_comb begin
        bad_o = ^word_i;
    end

endmodule

// File: rtl/sbg_subst.sv
// Module: sbg_subst
// Combinational AES substitution that yields a protected word: a constant
// table of TBL_N entries of {predicted check bit, S-box byte}, computed at
// elaboration. The output check bit is read from the table, never derived
// from the output byte. No memory or address decoder is implied.
module sbg_subst
    import sbg_pkg::*;
(
    input  byte_t addr_i,
    output word_t word_o
);

    word_t rom [TBL_N];

    // One constant entry per input value
    for (genvar gi = 0; gi < TBL_N; gi++) begin : g_rom
        localparam byte_t SV = sbox_fwd(byte_t'(gi));
        assign rom[gi] = protect(SV);
    end

    // Select the entry for the current byte
    always_comb begin
        word_o = rom[addr_i];
    end

endmodule

// File: rtl/sbg_top.sv
// Module: sbg_top
// Fault-checked AES substitution stage. Parity is verified on the word that
// enters the S-box and on the word that leaves it. A failure in either check
// stores ERR_PATTERN and sets err_q. res_q is cleared in every cycle
// without a write; err_q holds until the next write. Reset is synchronous and
// active low. Fault masks are test inputs, tied to zero in normal use.
module sbg_top
    import sbg_pkg::*;
#(
    parameter logic [7:0] ERR_PATTERN = 8'h01
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] pt_byte,
    input  logic [7:0] key_byte,
    input  logic [8:0] flt_pre,
    input  logic [8:0] flt_post,
    output logic [7:0] res_q,
    output logic       err_q
);

    word_t enc_word;
    word_t pre_word;
    word_t sub_word;
    word_t post_word;
    logic  pre_bad;
    logic  post_bad;
    logic  fail;

    sbg_encode u_encode (
        .pt_i   (pt_byte),
        .key_i  (key_byte),
        .word_o (enc_word)
    );

    // Apply the input-side test mask
    always_comb begin
        pre_word = enc_word ^ flt_pre;
    end

    sbg_check #(.W(WORD_W)) u_chk_pre (
        .word_i (pre_word),
        .bad_o  (pre_bad)
    );

    sbg_subst u_subst (
        .addr_i (pre_word[BYTE_W-1:0]),
        .word_o (sub_word)
    );

    // Apply the output-side test mask
    always_comb begin
        post_word = sub_word ^ flt_post;
    end

    sbg_check #(.W(WORD_W)) u_chk_post (
        .word_i (post_word),
        .bad_o  (post_bad)
    );

    // Merge both check results
    always_comb begin
        fail = pre_bad | post_bad;
    end

    // Output register: load on write, clear data otherwise, hold the flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            err_q <= 1'b0;
        end else if (wr_en) begin
            res_q <= fail ? ERR_PATTERN : post_word[BYTE_W-1:0];
            err_q <= fail;
        end else begin
            res_q <= '0;
        end
    end

endmodule

// File: rtl/sbg_sva.sv
// Module: sbg_sva
// Assertion checker for sbg_top, bound below. Observes ports only.
module sbg_sva #(
    parameter logic [7:0] ERR_PATTERN = 8'h01
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [8:0] flt_pre,
    input logic [8:0] flt_post,
    input logic [7:0] res_q,
    input logic       err_q
);

    AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (res_q == 8'h00)); // R3

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(err_q)); // R4

    AST_PRE_SINGLE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $countones(flt_pre) == 1 && flt_post == 9'h0)
        |=> (err_q && res_q == ERR_PATTERN)); // R5

    AST_POST_SINGLE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $countones(flt_post) == 1 && flt_pre == 9'h0)
        |=> (err_q && res_q == ERR_PATTERN)); // R6

    AST_CLEAN_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && flt_pre == 9'h0 && flt_post == 9'h0) |=> !err_q); // R2

    AST_FLAG_MEANS_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (!err_q || res_q == ERR_PATTERN)); // R5

endmodule

bind sbg_top sbg_sva #(.ERR_PATTERN(ERR_PATTERN)) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .flt_pre  (flt_pre),
    .flt_post (flt_post),
    .res_q    (res_q),
    .err_q    (err_q)
);

// File: tb/sbg_top_tb.sv
`timescale 1ns/1ps
module sbg_top_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] pt_byte = '0;
    logic [7:0] key_byte = '0;
    logic [8:0] flt_pre = '0;
    logic [8:0] flt_post = '0;
    logic [7:0] res_q;
    logic       err_q;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sbg_top u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .pt_byte  (pt_byte),
        .key_byte (key_byte),
        .flt_pre  (flt_pre),
        .flt_post (flt_post),
        .res_q    (res_q),
        .err_q    (err_q)
    );

    // GF(2^8) multiply used by the bench model
    function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] acc = '0;
        for (int i = 0; i < 8; i++) if (b[i]) acc ^= (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (acc[i]) acc ^= (16'h011b << (i - 8));
        return acc[7:0];
    endfunction

    // S-box by inverse search and bitwise affine formula
    function automatic logic [7:0] m_sbox(input logic [7:0] x);
        logic [7:0] inv = 8'h00;
        logic [7:0] s;
        logic [7:0] c = 8'h63;
        if (x != 0) begin
            for (int y = 1; y < 256; y++) if (m_mul(x, 8'(y)) == 8'h01) inv = 8'(y);
        end
        for (int i = 0; i < 8; i++)
            s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ c[i];
        return s;
    endfunction

    // Expected {err, res} of a write, from R2, R5, R6 and R9
    function automatic logic [8:0] m_write(input logic [7:0] p, input logic [7:0] k,
                                           input logic [8:0] fa, input logic [8:0] fb);
        logic [8:0] w1;
        logic [7:0] s;
        logic [8:0] w2;
        w1 = {^p ^ ^k, p ^ k} ^ fa;
        s  = m_sbox(w1[7:0]);
        w2 = {^s, s} ^ fb;
        if ((^w1) || (^w2)) return {1'b1, 8'h01};
        return {1'b0, w2[7:0]};
    endfunction

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Drive one write, then sample the loaded register
    task automatic do_write(input string req, input logic [7:0] p, input logic [7:0] k,
                            input logic [8:0] fa, input logic [8:0] fb);
        @(negedge clk);
        wr_en = 1'b1; pt_byte = p; key_byte = k; flt_pre = fa; flt_post = fb;
        @(negedge clk);
        wr_en = 1'b0; flt_pre = '0; flt_post = '0;
        check(req, {err_q, res_q}, m_write(p, k, fa, fb));
    endtask

    // One idle cycle: data clears, flag holds
    task automatic idle_check(input logic exp_err);
        @(negedge clk);
        check("R3", {1'b0, res_q}, 9'h000);
        check("R4", {8'h00, err_q}, {8'h00, exp_err});
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        logic [7:0] k;
        logic [8:0] e;
        void'($urandom(32'h5b0c_e11a));
        repeat (3) @(negedge clk);
        check("R1", {err_q, res_q}, 9'h000);
        rst_n = 1'b1;

        // R2: every S-box input, fault free, with random keys
        for (int i = 0; i < 256; i++) begin
            k = 8'($urandom);
            do_write("R2", 8'(i) ^ k, k, '0, '0);
            if (i % 32 == 0) idle_check(1'b0);
        end

        // R5 / R6: every single-bit fault on each side, then flag holds
        for (int b = 0; b < 9; b++) begin
            do_write("R5", 8'($urandom), 8'($urandom), 9'(1) << b, '0);
            idle_check(1'b1);
            do_write("R6", 8'($urandom), 8'($urandom), '0, 9'(1) << b);
            idle_check(1'b1);
        end

        // R7: masks while idle change nothing, clean and flagged states
        do_write("R2", 8'h3c, 8'ha5, '0, '0);
        @(negedge clk); flt_pre = 9'h1ff; flt_post = 9'h0aa;
        @(negedge clk); flt_pre = '0; flt_post = '0;
        check("R7", {err_q, res_q}, 9'h000);
        do_write("R5", 8'h11, 8'h22, 9'h004, '0);
        @(negedge clk); flt_post = 9'h100;
        @(negedge clk); flt_post = '0;
        check("R7", {err_q, res_q}, 9'h100);

        // R8: back-to-back writes, faulty then clean
        @(negedge clk);
        wr_en = 1'b1; pt_byte = 8'h53; key_byte = 8'h00; flt_pre = 9'h001;
        @(negedge clk);
        check("R8", {err_q, res_q}, 9'h101);
        pt_byte = 8'h00; key_byte = 8'h00; flt_pre = '0;
        @(negedge clk);
        check("R8", {err_q, res_q}, {1'b0, m_sbox(8'h00)});
        pt_byte = 8'hff; key_byte = 8'h0f;
        @(negedge clk);
        wr_en = 1'b0;
        check("R8", {err_q, res_q}, {1'b0, m_sbox(8'hf0)});
        idle_check(1'b0);

        // R9: two data-bit flips on input slip through
        do_write("R9", 8'h00, 8'h00, 9'h003, '0);
        check("R9", {1'b0, res_q}, {1'b0, m_sbox(8'h03)});
        do_write("R9", 8'h5a, 8'h00, 9'h081, '0);

        // Random mix, including faults on both sides in one write
        for (int t = 0; t < 400; t++) begin
            case ($urandom % 5)
                0: e = '0;
                1: e = 9'(1) << ($urandom % 9);
                2: e = (9'(1) << ($urandom % 8)) | (9'(1) << (($urandom % 7) + 1));
                default: e = 9'($urandom);
            endcase
            if ($urandom % 2) do_write("R9", 8'($urandom), 8'($urandom), e, '0);
            else do_write("R6", 8'($urandom), 8'($urandom), e, 9'($urandom) & 9'h1ff);
            if (t % 50 == 0) idle_check(err_q);
        end

        finish_run();
    end

endmodule